// File: doc/BRIEF.md
# Paged expanded-RAM access unit

This unit handles the 8-bit indirect data accesses of a small microcontroller core. The core gives a low address byte, a read/write flag, write data and the current port-2 byte. The unit holds a 768-byte on-chip data RAM, arranged as three 256-byte pages. A control register selects the page. Each access goes either to a page of the on-chip RAM or out to an external memory bus.

The page-select field has four codes. Three of them name internal pages, and the two page bits form the upper part of the RAM index. The fourth code sends the access off-chip: the port-2 byte becomes address bits 15:8 and the low byte becomes bits 7:0. A separate enable bit turns the on-chip RAM on. While it is clear, every access goes to the external bus with that same address formation.

An internal access finishes in one clock. An external access holds its strobe for a fixed number of wait cycles, which is a parameter. Only one access can be in flight at a time, and `busy_o` holds off new requests until the external access completes.

Top module: `xram_page_unit`

## Requirements
- R1: After reset the control register reads 00h (page 0, RAM disabled), and done_o, busy_o, ext_rd_o and ext_wr_o are all 0.
- R2: The control register is at SFR address CTRL_ADDR (default 85h). Bits 1:0 are the page select, bit 4 is the RAM enable (1 = on), and all other bits read 0 and ignore writes. A write to any other SFR address leaves the register unchanged, and a read of any other address returns 00h.
- R3: With the RAM enabled, page codes 00, 01 and 10 map low address L to RAM locations L, 100h+L and 200h+L. A byte written with page 01 at 45h reads back from page 01 at 45h and does not appear at page 00 or page 10 location 45h.
- R4: An internal access accepted at a clock edge raises done_o for the following cycle, returns read data in that same cycle, and never asserts an external strobe.
- R5: With page code 11, the access goes to the external bus at address {port-2 byte, low byte}.
- R6: With the RAM enable at 0, accesses with page code 00, 01 or 10 also go to the external bus at address {port-2 byte, low byte}.
- R7: An external access asserts ext_rd_o (read) or ext_wr_o (write) for exactly WAIT consecutive cycles, samples ext_rdata_i in the last of them, and raises done_o with that data in the cycle after.
- R8: busy_o is high for the whole external strobe period. A request presented while busy_o is high is ignored: the bus address and the strobe length do not change.
- R9: During an external write, ext_wdata_o carries the write byte. ext_rd_o and ext_wr_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sfr_addr_i | input | 8 | SFR address for register write/read |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data (combinational on address) |
| req_i | input | 1 | Access request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| lo_addr_i | input | 8 | Low address byte from the indirect register |
| hi_byte_i | input | 8 | Current port-2 byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while done_o is high after a read |
| done_o | output | 1 | Access-complete pulse |
| busy_o | output | 1 | External access in progress |
| ext_addr_o | output | 16 | External bus address |
| ext_wdata_o | output | 8 | External bus write data |
| ext_rdata_i | input | 8 | External bus read data |
| ext_rd_o | output | 1 | External read strobe |
| ext_wr_o | output | 1 | External write strobe |

## Verification
The same low address 45h is written with different data to each of the three internal pages and then read back. This separates a correct page decode from an aliased or swapped one. Page code 11 and a cleared enable bit are both run with distinct port-2 and low bytes, including FFh, so a swapped or truncated external address is exposed. The bench model returns a filler value on the external read data in every strobe cycle except the last, which shows whether the sample is taken on the right cycle. A competing request injected mid-strobe shows whether the busy hold-off works.

// File: rtl/xram_pkg.sv
package xram_pkg;
  localparam int unsigned PAGE_W = 2;

  typedef enum logic [PAGE_W-1:0] {
    PG_0   = 2'b00,
    PG_1   = 2'b01,
    PG_2   = 2'b10,
    PG_EXT = 2'b11
  } page_sel_e;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [7:0]  wdata;
  } ext_req_t;
endpackage

// File: rtl/xram_ctrl_reg.sv
module xram_ctrl_reg
  import xram_pkg::*;
#(
  parameter logic [7:0] CTRL_ADDR = 8'h85,
  parameter int unsigned EN_BIT   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [7:0]      sfr_addr_i,
  input  logic            sfr_wr_i,
  input  logic [7:0]      sfr_wdata_i,
  output logic [7:0]      sfr_rdata_o,
  output page_sel_e       page_o,
  output logic            ram_en_o
);
  logic hit;
  assign hit = (sfr_addr_i == CTRL_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o   <= PG_0;
      ram_en_o <= 1'b0;
    end else if (sfr_wr_i && hit) begin
      page_o   <= page_sel_e'(sfr_wdata_i[PAGE_W-1:0]);
      ram_en_o <= sfr_wdata_i[EN_BIT];
    end
  end

  always_comb begin
    sfr_rdata_o = '0;
    if (hit) begin
      sfr_rdata_o[PAGE_W-1:0] = page_o;
      sfr_rdata_o[EN_BIT]     = ram_en_o;
    end
  end

  // R2
  foreign_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_wr_i && !hit) |=> ($stable(page_o) && $stable(ram_en_o)));
endmodule

// File: rtl/xram_store.sv
module xram_store #(
  parameter int unsigned PAGES = 3,
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [1:0]    page_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = PAGES << AW;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic [IDX_W-1:0] idx;

  assign idx = (IDX_W'(page_i) << AW) | IDX_W'(addr_i);

  always_ff @(posedge clk_i) begin
    if (en_i && we_i) mem[idx] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rdata_o <= '0;
    else if (en_i && !we_i) rdata_o <= mem[idx];
  end

  // R3
  page_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (32'(page_i) < PAGES));
endmodule

// File: rtl/xram_ext_port.sv
module xram_ext_port
  import xram_pkg::*;
#(
  parameter int unsigned WAIT = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  ext_req_t    req_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  rdata_o,
  output logic [15:0] ext_addr_o,
  output logic [7:0]  ext_wdata_o,
  input  logic [7:0]  ext_rdata_i,
  output logic        ext_rd_o,
  output logic        ext_wr_o
);
  localparam int unsigned CNT_W = (WAIT > 1) ? $clog2(WAIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT - 1);

  ext_req_t         cur_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      cnt_q   <= '0;
      cur_q   <= '0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt_q  <= CNT_LAST;
        cur_q  <= req_i;
      end else if (last) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
        if (!cur_q.we) rdata_o <= ext_rdata_i;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign ext_addr_o  = cur_q.addr;
  assign ext_wdata_o = cur_q.wdata;
  assign ext_rd_o    = busy_o && !cur_q.we;
  assign ext_wr_o    = busy_o &&  cur_q.we;

  // R7
  last_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |=> (done_o && !busy_o));
  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(ext_addr_o) && $stable(ext_wdata_o)));
endmodule

// File: rtl/xram_page_unit.sv
module xram_page_unit
  import xram_pkg::*;
#(
  parameter logic [7:0]  CTRL_ADDR = 8'h85,
  parameter int unsigned WAIT      = 2,
  parameter int unsigned PAGES     = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  sfr_addr_i,
  input  logic        sfr_wr_i,
  input  logic [7:0]  sfr_wdata_i,
  output logic [7:0]  sfr_rdata_o,
  input  logic        req_i,
  input  logic        req_we_i,
  input  logic [7:0]  lo_addr_i,
  input  logic [7:0]  hi_byte_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        done_o,
  output logic        busy_o,
  output logic [15:0] ext_addr_o,
  output logic [7:0]  ext_wdata_o,
  input  logic [7:0]  ext_rdata_i,
  output logic        ext_rd_o,
  output logic        ext_wr_o
);
  page_sel_e  page;
  logic       ram_en, accept, to_ext, int_go, ext_go;
  logic       int_done_q, src_ext_q, ext_done;
  logic [7:0] int_rdata, ext_rdata;
  ext_req_t   ext_req;

  xram_ctrl_reg #(.CTRL_ADDR(CTRL_ADDR), .EN_BIT(4)) u_ctrl (
    .clk_i, .rst_ni, .sfr_addr_i, .sfr_wr_i, .sfr_wdata_i, .sfr_rdata_o,
    .page_o(page), .ram_en_o(ram_en)
  );

  assign accept = req_i && !busy_o;
  assign to_ext = !ram_en || (page == PG_EXT);
  assign int_go = accept && !to_ext;
  assign ext_go = accept && to_ext;

  assign ext_req.we    = req_we_i;
  assign ext_req.addr  = {hi_byte_i, lo_addr_i};
  assign ext_req.wdata = wdata_i;

  xram_store #(.PAGES(PAGES), .AW(8), .DW(8)) u_store (
    .clk_i, .rst_ni, .en_i(int_go), .we_i(req_we_i), .page_i(page),
    .addr_i(lo_addr_i), .wdata_i, .rdata_o(int_rdata)
  );

  xram_ext_port #(.WAIT(WAIT)) u_ext (
    .clk_i, .rst_ni, .start_i(ext_go), .req_i(ext_req), .busy_o,
    .done_o(ext_done), .rdata_o(ext_rdata), .ext_addr_o, .ext_wdata_o,
    .ext_rdata_i, .ext_rd_o, .ext_wr_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_done_q <= 1'b0;
      src_ext_q  <= 1'b0;
    end else begin
      int_done_q <= int_go;
      if (accept) src_ext_q <= to_ext;
    end
  end

  assign done_o  = int_done_q | ext_done;
  assign rdata_o = src_ext_q ? ext_rdata : int_rdata;

  // R4
  int_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_go |=> (done_o && !ext_rd_o && !ext_wr_o));
  // R8
  busy_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_rd_o && ext_wr_o));
endmodule

// File: tb/xram_page_unit_bench.sv
module xram_page_unit_bench;
  localparam int WAIT = 3;
  localparam logic [7:0] CA = 8'h85;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
  logic sfr_wr = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [7:0] lo = '0, hi = '0, wd = '0, rdata, ext_wdata, ext_rdata = 8'hEE;
  logic done, busy, ext_rd, ext_wr;
  logic [15:0] ext_addr;
  int checks = 0, errors = 0;
  bit wd_expired = 1'b0;

  always #4 clk = ~clk;

  xram_page_unit #(.CTRL_ADDR(CA), .WAIT(WAIT)) u_xram_page_unit (
    .clk_i(clk), .rst_ni(rst_n), .sfr_addr_i(sfr_addr), .sfr_wr_i(sfr_wr),
    .sfr_wdata_i(sfr_wdata), .sfr_rdata_o(sfr_rdata), .req_i(req),
    .req_we_i(req_we), .lo_addr_i(lo), .hi_byte_i(hi), .wdata_i(wd),
    .rdata_o(rdata), .done_o(done), .busy_o(busy), .ext_addr_o(ext_addr),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata), .ext_rd_o(ext_rd),
    .ext_wr_o(ext_wr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = v; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = CA;
  endtask

  task automatic sfr_expect(input logic [7:0] a, input logic [7:0] exp, input string rq);
    sfr_addr = a; #1;
    chk(sfr_rdata == exp, rq, sfr_rdata, exp);
    sfr_addr = CA;
  endtask

  // one access; checks routing, timing, data and busy hold-off
  task automatic access(input logic we, input logic [7:0] l, input logic [7:0] h,
                        input logic [7:0] d, input logic exp_ext,
                        input logic [7:0] exp_rd, input string rq);
    int n = 0;
    logic [7:0] ext_val;
    ext_val = h ^ ~l;
    @(negedge clk);
    req = 1'b1; req_we = we; lo = l; hi = h; wd = d;
    @(negedge clk);
    req = 1'b0;
    if (!exp_ext) begin
      chk(done && !ext_rd && !ext_wr && !busy, {rq, " R4 internal done"},
          {done, ext_rd, ext_wr, busy}, 4'b1000);
      if (!we) chk(rdata == exp_rd, {rq, " R3 internal data"}, rdata, exp_rd);
    end else begin
      while ((ext_rd || ext_wr) && n < 20) begin
        n++;
        chk(busy && !done, {rq, " R8 busy"}, {busy, done}, 2'b10);
        chk(ext_addr == {h, l}, {rq, " R5 R6 address"}, ext_addr, {h, l});
        chk(ext_rd == !we && ext_wr == we, {rq, " R9 strobe"}, {ext_rd, ext_wr}, {!we, we});
        if (we) chk(ext_wdata == d, {rq, " R9 wdata"}, ext_wdata, d);
        ext_rdata = (n == WAIT) ? ext_val : 8'hEE;
        // competing request in the first strobe cycle must be ignored
        req = (n == 1); lo = ~l; hi = ~h;
        @(negedge clk);
        req = 1'b0;
      end
      ext_rdata = 8'hEE;
      chk(n == WAIT, {rq, " R7 strobe length"}, n, WAIT);
      chk(done && !busy, {rq, " R7 done after strobe"}, {done, busy}, 2'b10);
      if (!we) chk(rdata == ext_val, {rq, " R7 sampled data"}, rdata, ext_val);
    end
    @(negedge clk);
    chk(!done && !ext_rd && !ext_wr, {rq, " R8 no extra access"}, {done, ext_rd, ext_wr}, 0);
  endtask

  task automatic t_reset;
    sfr_expect(CA, 8'h00, "R1 ctrl reset");
    chk(!done && !busy && !ext_rd && !ext_wr, "R1 outputs idle",
        {done, busy, ext_rd, ext_wr}, 0);
  endtask

  task automatic t_reg;
    sfr_write(CA, 8'hFF);
    sfr_expect(CA, 8'h13, "R2 only defined bits");
    sfr_write(CA, 8'h00);
    sfr_expect(CA, 8'h00, "R2 clear");
    sfr_write(8'h86, 8'hFF);
    sfr_expect(CA, 8'h00, "R2 foreign write ignored");
    sfr_expect(8'h86, 8'h00, "R2 foreign read zero");
  endtask

  task automatic t_pages;
    sfr_write(CA, 8'h10); access(1'b1, 8'h45, 8'h00, 8'h11, 1'b0, 8'h0, "R3 p0 wr");
    sfr_write(CA, 8'h11); access(1'b1, 8'h45, 8'h00, 8'hA5, 1'b0, 8'h0, "R3 p1 wr");
    sfr_write(CA, 8'h12); access(1'b1, 8'h45, 8'h00, 8'h3C, 1'b0, 8'h0, "R3 p2 wr");
    access(1'b1, 8'hFF, 8'h00, 8'h96, 1'b0, 8'h0, "R3 p2 top wr");
    sfr_write(CA, 8'h11); access(1'b0, 8'h45, 8'h00, 8'h0, 1'b0, 8'hA5, "R3 p1 rd");
    sfr_write(CA, 8'h10); access(1'b0, 8'h45, 8'h00, 8'h0, 1'b0, 8'h11, "R3 p0 rd");
    sfr_write(CA, 8'h12); access(1'b0, 8'h45, 8'h00, 8'h0, 1'b0, 8'h3C, "R3 p2 rd");
    access(1'b0, 8'hFF, 8'h00, 8'h0, 1'b0, 8'h96, "R3 p2 top rd");
  endtask

  task automatic t_ext_page;
    sfr_write(CA, 8'h13);
    access(1'b1, 8'h34, 8'h12, 8'h77, 1'b1, 8'h0, "R5 page11 wr");
    access(1'b0, 8'hCD, 8'hAB, 8'h0, 1'b1, 8'h0, "R5 page11 rd");
    access(1'b0, 8'hFF, 8'hFF, 8'h0, 1'b1, 8'h0, "R5 page11 top");
  endtask

  task automatic t_disabled;
    sfr_write(CA, 8'h01);
    access(1'b0, 8'h45, 8'h5E, 8'h0, 1'b1, 8'h0, "R6 disabled rd");
    access(1'b1, 8'h45, 8'h00, 8'h22, 1'b1, 8'h0, "R6 disabled wr");
    sfr_write(CA, 8'h11);
    access(1'b0, 8'h45, 8'h00, 8'h0, 1'b0, 8'hA5, "R6 ram untouched");
  endtask

  initial begin
    #200000;
    wd_expired = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg();
        t_pages();
        t_ext_page();
        t_disabled();
      end
      begin
        wait (wd_expired);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule